// File: doc/BRIEF.md
# Audio Clock Divider Chain

This block derives two audio clocks from a single fast system clock: a master clock for an external converter and a serial bit clock for the sample stream. Both source clocks reach the block as single-cycle tick enables in the system clock domain, and a select bit decides which of them feeds the chain. Inside the chain the selected ticks pass through four stages in turn. The first is a prescaler that divides by 1 or by 8. The second is a modulus counter that divides by 1 to 256. A toggle stage follows, which halves the rate so that every ratio is even, and it produces the master clock. The last stage is a tail counter that divides by 1 to 16. It acts only on the bit clock. A bypass setting sends each source tick straight to the master clock instead, which gives a ratio of 1.

The block drives each clock as a level, with a polarity bit applied, and as a one-cycle strobe that marks the rising edge of the level before any inversion. The level is useful as a pin, and the strobe can serve as an enable for logic that runs on the system clock. Software writes a divide setting at any time. The new value takes effect only at the next terminal count of the stage it belongs to, so the change never cuts short a half-period that is already running.

The controller has three states. ST_IDLE lasts one cycle after reset. ST_DIV runs the divider path and ST_BYP runs the bypass path. ST_IDLE moves to ST_BYP when the bypass setting is 1 and to ST_DIV when it is 0. ST_DIV moves to ST_BYP at a modulus terminal count when the bypass setting is 1. ST_BYP moves to ST_DIV at a selected source tick when the bypass setting is 0.

Top module: `acd_chain`

## Requirements
- R1: While the synchronous active-high reset is high, and in the first cycle after it is released, all four outputs are 0 and all counters are cleared.
- R2: When `cfg_pre8` is 1, the prescaler divides the selected ticks by 8; when it is 0, it passes them at ratio 1.
- R3: `cfg_mod_div` holds the modulus ratio minus one. A value of 0 divides by 1 and a value of 255 divides by 256. Each modulus terminal count toggles the master clock level.
- R4: In divide mode the master clock period is 2·P·M source ticks, where P is the prescaler ratio and M is the modulus ratio. Its high time is P·M ticks, which gives a 50% duty cycle.
- R5: `cfg_tail_div` holds the tail ratio T minus one (0 to 15). The bit clock level toggles after every T half-periods of the master clock, so its period is 2·P·M·T ticks with a 50% duty cycle. T does not change the master clock.
- R6: When `cfg_bypass` is 1, each source tick drives the master clock level high for one system cycle and pulses `mclk_rise_o`, which gives a ratio of 1. The bit clock then toggles after every T source ticks.
- R7: `cfg_src_sel` at 0 selects `src_a_tick` and at 1 selects `src_b_tick`. The other tick input has no effect.
- R8: `cfg_mclk_inv` and `cfg_bclk_inv` invert `mclk_o` and `bclk_o` respectively. The strobes always follow the un-inverted level.
- R9: A change to the prescaler, modulus, select or bypass setting takes effect at the next modulus terminal count, and a change to the tail setting takes effect at the next tail terminal count. A half-period that is already running keeps its old length.
- R10: `mclk_rise_o` and `bclk_rise_o` pulse for one cycle in exactly the cycle in which the matching un-inverted level goes from 0 to 1.
- R11: The largest settings give a master clock ratio of 2·8·256 = 4096 and a bit clock ratio of 2·256·16 = 8192 with the prescaler off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_tick | input | 1 | Tick enable of source clock A |
| src_b_tick | input | 1 | Tick enable of source clock B |
| cfg_src_sel | input | 1 | Source select: 0 selects A, 1 selects B |
| cfg_pre8 | input | 1 | Prescaler ratio: 1 selects divide by 8, 0 selects divide by 1 |
| cfg_mod_div | input | 8 | Modulus ratio minus one |
| cfg_tail_div | input | 4 | Bit clock tail ratio minus one |
| cfg_bypass | input | 1 | Sends source ticks straight to the master clock |
| cfg_mclk_inv | input | 1 | Inverts the master clock level |
| cfg_bclk_inv | input | 1 | Inverts the bit clock level |
| mclk_o | output | 1 | Master clock level |
| mclk_rise_o | output | 1 | Rising-edge strobe of the master clock |
| bclk_o | output | 1 | Bit clock level |
| bclk_rise_o | output | 1 | Rising-edge strobe of the bit clock |

## Verification
The hardest case to reach is a divide setting that changes while a half-period is running. The bench waits for a master clock rising strobe, writes a new modulus three cycles into the high half, and then measures how long each of the next two halves lasts. The high half must keep its old length and the low half must have the new one. Mode and source switches also land at arbitrary source phases. For that reason every configuration in the sweep first discards one full bit clock period, and only then measures periods and high times in system cycles. The expected values come from the tick spacing of each source multiplied by the stage ratios.

// File: rtl/acd_pkg.sv
package acd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_BYP  = 2'd2
    } acd_state_e;

endpackage

// File: rtl/acd_divcnt.sv
// Programmable modulus counter: counts input ticks from 0 up to lim_i and
// flags the tick that reaches the limit as its terminal count.
module acd_divcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic [W-1:0] lim_i,
    output logic [W-1:0] cnt_o,
    output logic         term_o
);

    logic [W-1:0] cnt_q;

    always_comb begin
        term_o = tick_i && (cnt_q >= lim_i);
        cnt_o  = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= term_o ? '0 : cnt_q + 1'b1;
        end
    end

    // limits only change at a terminal count, so the count never passes them
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_i);  // R3

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        term_o |=> (cnt_q == '0));  // R9

endmodule

// File: rtl/acd_chain.sv
module acd_chain
    import acd_pkg::*;
#(
    parameter int MOD_W  = 8,
    parameter int TAIL_W = 4,
    parameter int PRE_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_a_tick,
    input  logic              src_b_tick,
    input  logic              cfg_src_sel,
    input  logic              cfg_pre8,
    input  logic [MOD_W-1:0]  cfg_mod_div,
    input  logic [TAIL_W-1:0] cfg_tail_div,
    input  logic              cfg_bypass,
    input  logic              cfg_mclk_inv,
    input  logic              cfg_bclk_inv,
    output logic              mclk_o,
    output logic              mclk_rise_o,
    output logic              bclk_o,
    output logic              bclk_rise_o
);

    localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

    acd_state_e state_q, state_d;

    // settings in use by the counters
    logic              sel_q;
    logic              pre_q;
    logic [MOD_W-1:0]  mod_q;
    logic [TAIL_W-1:0] tail_q;

    logic              src_tick;
    logic              pre_tick;
    logic              pre_term;
    logic              mod_term;
    logic              half_edge;
    logic              tail_term;
    logic [PRE_W-1:0]  pre_lim;
    logic [PRE_W-1:0]  pre_cnt;
    logic [MOD_W-1:0]  mod_cnt;
    logic [TAIL_W-1:0] tail_cnt;

    logic mclk_lvl_q, mclk_lvl_d;
    logic bclk_lvl_q, bclk_lvl_d;
    logic mclk_rise_q, bclk_rise_q;
    logic mclk_q, bclk_q;

    // ---------------- datapath selection ----------------
    always_comb begin
        src_tick = sel_q ? src_b_tick : src_a_tick;
        pre_tick = (state_q == ST_DIV) && src_tick;
        pre_lim  = pre_q ? PRE_TOP : '0;
    end

    acd_divcnt #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_i (pre_tick),
        .lim_i  (pre_lim),
        .cnt_o  (pre_cnt),
        .term_o (pre_term)
    );

    acd_divcnt #(.W(MOD_W)) u_mod (
        .clk    (clk),
        .rst    (rst),
        .tick_i (pre_term),
        .lim_i  (mod_q),
        .cnt_o  (mod_cnt),
        .term_o (mod_term)
    );

    always_comb begin
        unique case (state_q)
            ST_DIV:  half_edge = mod_term;
            ST_BYP:  half_edge = src_tick;
            default: half_edge = 1'b0;
        endcase
    end

    acd_divcnt #(.W(TAIL_W)) u_tail (
        .clk    (clk),
        .rst    (rst),
        .tick_i (half_edge),
        .lim_i  (tail_q),
        .cnt_o  (tail_cnt),
        .term_o (tail_term)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = cfg_bypass ? ST_BYP : ST_DIV;
            ST_DIV:  if (half_edge && cfg_bypass)  state_d = ST_BYP;
            ST_BYP:  if (half_edge && !cfg_bypass) state_d = ST_DIV;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- output process ----------------
    always_comb begin
        unique case (state_q)
            ST_DIV:  mclk_lvl_d = mclk_lvl_q ^ half_edge;
            ST_BYP:  mclk_lvl_d = src_tick;
            default: mclk_lvl_d = 1'b0;
        endcase
        bclk_lvl_d = (state_q == ST_IDLE) ? 1'b0 : (bclk_lvl_q ^ tail_term);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mclk_lvl_q  <= 1'b0;
            bclk_lvl_q  <= 1'b0;
            mclk_rise_q <= 1'b0;
            bclk_rise_q <= 1'b0;
            mclk_q      <= 1'b0;
            bclk_q      <= 1'b0;
        end else begin
            mclk_lvl_q  <= mclk_lvl_d;
            bclk_lvl_q  <= bclk_lvl_d;
            mclk_rise_q <= mclk_lvl_d & ~mclk_lvl_q;
            bclk_rise_q <= bclk_lvl_d & ~bclk_lvl_q;
            mclk_q      <= mclk_lvl_d ^ cfg_mclk_inv;
            bclk_q      <= bclk_lvl_d ^ cfg_bclk_inv;
        end
    end

    // ---------------- settings taken at terminal counts ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= cfg_src_sel;
            pre_q  <= cfg_pre8;
            mod_q  <= cfg_mod_div;
            tail_q <= cfg_tail_div;
        end else begin
            if (half_edge) begin
                sel_q <= cfg_src_sel;
                pre_q <= cfg_pre8;
                mod_q <= cfg_mod_div;
            end
            if (tail_term) begin
                tail_q <= cfg_tail_div;
            end
        end
    end

    always_comb begin
        mclk_o      = mclk_q;
        mclk_rise_o = mclk_rise_q;
        bclk_o      = bclk_q;
        bclk_rise_o = bclk_rise_q;
    end

    // ---------------- assertions ----------------
    AST_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mclk_o && !bclk_o && !mclk_rise_o && !bclk_rise_o));  // R1

    AST_MCLK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIV && !mod_term) |=> $stable(mclk_lvl_q));  // R4

    AST_BCLK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tail_term |=> $stable(bclk_lvl_q));  // R5

    AST_TAIL_RESTART: assert property (@(posedge clk) disable iff (rst)
        tail_term |=> (tail_cnt == '0));  // R5

    AST_BYP_COUNTERS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BYP) |-> (pre_cnt == '0 && mod_cnt == '0));  // R6

    AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIV && !mod_term) |=> ($stable(mod_q) && $stable(pre_q) && $stable(sel_q)));  // R9

    AST_MCLK_RISE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        mclk_rise_q |-> mclk_lvl_q);  // R10

    AST_BCLK_RISE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        bclk_rise_q |-> bclk_lvl_q);  // R10

endmodule

// File: tb/acd_chain_tb_top.sv
module acd_chain_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst;
    logic       src_a_tick, src_b_tick;
    logic       cfg_src_sel, cfg_pre8, cfg_bypass, cfg_mclk_inv, cfg_bclk_inv;
    logic [7:0] cfg_mod_div;
    logic [3:0] cfg_tail_div;
    logic       mclk_o, mclk_rise_o, bclk_o, bclk_rise_o;

    int total = 0;
    int fails = 0;
    bit done  = 0;
    int ca    = 0;
    int cb    = 0;

    localparam int SPACE_A = 2;
    localparam int SPACE_B = 3;

    acd_chain dut_i (
        .clk          (clk),
        .rst          (rst),
        .src_a_tick   (src_a_tick),
        .src_b_tick   (src_b_tick),
        .cfg_src_sel  (cfg_src_sel),
        .cfg_pre8     (cfg_pre8),
        .cfg_mod_div  (cfg_mod_div),
        .cfg_tail_div (cfg_tail_div),
        .cfg_bypass   (cfg_bypass),
        .cfg_mclk_inv (cfg_mclk_inv),
        .cfg_bclk_inv (cfg_bclk_inv),
        .mclk_o       (mclk_o),
        .mclk_rise_o  (mclk_rise_o),
        .bclk_o       (bclk_o),
        .bclk_rise_o  (bclk_rise_o)
    );

    // free-running source tick generators
    initial begin
        src_a_tick = 1'b0;
        src_b_tick = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            src_a_tick = (ca == 0);
            src_b_tick = (cb == 0);
            ca = (ca + 1) % SPACE_A;
            cb = (cb + 1) % SPACE_B;
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(bit sel, bit pre, int m, int t, bit byp, bit im, bit ib);
        cfg_src_sel  = sel;
        cfg_pre8     = pre;
        cfg_mod_div  = 8'(m - 1);
        cfg_tail_div = 4'(t - 1);
        cfg_bypass   = byp;
        cfg_mclk_inv = im;
        cfg_bclk_inv = ib;
    endtask

    // period and high time in system cycles, rise to rise
    task automatic meas_m(output int per, output int hi, output int rise_lvl);
        @(negedge clk);
        while (!mclk_rise_o) @(negedge clk);
        rise_lvl = int'(mclk_o ^ cfg_mclk_inv);
        per = 0;
        hi  = 0;
        do begin
            per++;
            if (mclk_o ^ cfg_mclk_inv) hi++;
            @(negedge clk);
        end while (!mclk_rise_o);
    endtask

    task automatic meas_b(output int per, output int hi, output int rise_lvl);
        @(negedge clk);
        while (!bclk_rise_o) @(negedge clk);
        rise_lvl = int'(bclk_o ^ cfg_bclk_inv);
        per = 0;
        hi  = 0;
        do begin
            per++;
            if (bclk_o ^ cfg_bclk_inv) hi++;
            @(negedge clk);
        end while (!bclk_rise_o);
    endtask

    task automatic run_case(bit sel, bit pre, int m, int t, bit byp, bit im, bit ib,
                            string mtag, string btag);
        int per, hi, rl;
        int sp, p, e_mper, e_mhi, e_bper, e_bhi;
        set_cfg(sel, pre, m, t, byp, im, ib);
        sp = sel ? SPACE_B : SPACE_A;
        p  = pre ? 8 : 1;
        if (byp) begin
            e_mper = sp;
            e_mhi  = 1;
            e_bper = 2 * t * sp;
            e_bhi  = t * sp;
        end else begin
            e_mper = 2 * p * m * sp;
            e_mhi  = p * m * sp;
            e_bper = e_mper * t;
            e_bhi  = e_mhi * t;
        end
        meas_b(per, hi, rl);   // settles onto the new settings
        meas_b(per, hi, rl);
        check(btag, "bclk period", per, e_bper);
        check("R5", "bclk high time", hi, e_bhi);
        check("R10", "bclk level at rise strobe", rl, 1);
        meas_m(per, hi, rl);
        meas_m(per, hi, rl);
        check(mtag, "mclk period", per, e_mper);
        check(byp ? "R6" : "R4", "mclk high time", hi, e_mhi);
        check("R10", "mclk level at rise strobe", rl, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 190000, 0);
            report();
        end
    end

    initial begin
        int n;
        int n2;
        set_cfg(0, 0, 2, 1, 0, 0, 0);
        rst = 1'b1;
        repeat (5) @(negedge clk);
        // R1: outputs low while reset is high
        check("R1", "mclk_o in reset", int'(mclk_o), 0);
        check("R1", "bclk_o in reset", int'(bclk_o), 0);
        check("R1", "strobes in reset", int'(mclk_rise_o | bclk_rise_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "mclk_o after release", int'(mclk_o), 0);
        check("R1", "bclk_o after release", int'(bclk_o), 0);

        // R3/R5 sweep of modulus and tail ratios
        for (int m = 1; m <= 6; m++) begin
            for (int t = 1; t <= 4; t++) begin
                run_case(0, 0, m, t, 0, 0, 0, "R3", "R5");
            end
        end
        // R2 prescaler
        run_case(0, 1, 3, 2, 0, 0, 0, "R2", "R2");
        run_case(0, 1, 1, 1, 0, 0, 0, "R2", "R2");
        // R7 source B
        run_case(1, 0, 5, 3, 0, 0, 0, "R7", "R7");
        run_case(1, 1, 2, 2, 0, 0, 0, "R7", "R7");
        // R6 bypass on each source
        run_case(0, 0, 1, 3, 1, 0, 0, "R6", "R6");
        run_case(1, 0, 7, 2, 1, 0, 0, "R6", "R6");
        // R8 polarity
        run_case(0, 0, 4, 2, 0, 1, 1, "R8", "R8");
        run_case(0, 0, 4, 2, 0, 1, 0, "R8", "R8");
        run_case(0, 0, 1, 2, 1, 0, 1, "R8", "R8");
        // R11 extremes
        run_case(0, 1, 256, 1, 0, 0, 0, "R11", "R11");
        run_case(0, 0, 256, 16, 0, 0, 0, "R11", "R11");
        run_case(0, 0, 1, 16, 0, 0, 0, "R5", "R11");

        // R9: modulus change in the middle of a high half
        run_case(0, 0, 10, 1, 0, 0, 0, "R3", "R5");
        @(negedge clk);
        while (!mclk_rise_o) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 3) cfg_mod_div = 8'd0;
        end while (mclk_o == 1'b1);
        check("R9", "running half keeps old length", n, 10 * SPACE_A);
        n2 = 0;
        do begin
            @(negedge clk);
            n2++;
        end while (mclk_o == 1'b0);
        check("R9", "next half uses new length", n2, 1 * SPACE_A);

        done = 1;
        report();
    end

endmodule